// File: doc/BRIEF.md
# Sector Task-File Register Device

This block is the device end of a small parallel-disk register interface. A host drives a byte-wide bus with a three-bit offset. A separate select line reaches a control register at its own address. Through the byte bus the host loads a sector count, a 28-bit logical block address split over three bytes and a packed drive/head byte. It then writes a command code. The device answers with a status byte and an error-cause byte.

Sector payloads travel over a dedicated 32-bit data port. That port is backed by an internal buffer of one sector, 128 words of 32 bits. A read-sector command fills the buffer from a modelled medium and then offers the words for the host to read. A write-sector command takes 128 words from the host and then spends a commit period busy. The time spent busy is a parameter. Every finished sector, and every aborted command, raises an interrupt unless the host has masked it.

The medium is modelled by a fixed pattern derived from the block address. This gives a read command checkable content without storing any disk image.

Top module: `sector_taskfile`

## Requirements
- R1: After rst_n is released, status reads 0x80 for BUSY_CYCLES cycles and then 0x40. The error byte reads 0 and irq is low.
- R2: The byte-bus offsets read back what was written: 2 is sector count, 3, 4 and 5 are address bits 7:0, 15:8 and 23:16, and 6 is the drive/head byte. In the drive/head byte, bit 6 selects block addressing and bits 3:0 are address bits 27:24. Byte offset 0 reads 0.
- R3: A write to offset 7 while not busy is a command. For the BUSY_CYCLES cycles after that write, status reads exactly 0x80, because bit 7 (busy) hides every other bit.
- R4: Command 0x20 (read sector) stays busy for BUSY_CYCLES+128 cycles and then reads 0x48, which is ready (bit 6) plus data request (bit 3). Data word i then reads {address[24:0], i[6:0]}, and each data-port read advances to the next word. After the 128th read, status returns to 0x40.
- R5: Command 0x30 (write sector) reads 0x48 after BUSY_CYCLES cycles and accepts 128 data-port writes. It then reads 0x80 for BUSY_CYCLES cycles and then 0x40.
- R6: A completed sector (read data ready, or write committed) sets a pending interrupt. Reading status at offset 7 clears it one cycle later. Reading the same status through the control address does not clear it.
- R7: Bit 1 of the control register masks irq. Clearing that bit shows an interrupt that is still pending.
- R8: Each of these cases aborts the command after BUSY_CYCLES cycles: a code that is neither 0x20 nor 0x30, a sector count other than 1, or drive/head bit 6 clear. On abort, status reads 0x41 (bit 0 is the error bit), the error byte at offset 1 reads 0x04 (bit 2 is the abort cause), no data request is raised, and an interrupt is raised.
- R9: Byte-bus writes to offsets 1 to 7 while busy are ignored, both register values and commands.
- R10: Writing bit 2 of the control register starts a device reset. Status reads 0x80 for BUSY_CYCLES cycles and then 0x40, and the task-file registers, the error byte and any transfer are cleared.
- R11: Outside a read transfer, dat_rdata is 0, and data-port reads and writes leave the word position unchanged.
- R12: An accepted command clears the error bit and the error byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_ctl | input | 1 | Selects the control address instead of the task-file offsets |
| bus_addr | input | 3 | Task-file offset |
| bus_wr | input | 1 | Byte-bus write strobe |
| bus_rd | input | 1 | Byte-bus read strobe (side effects only) |
| bus_wdata | input | 8 | Byte-bus write data |
| bus_rdata | output | 8 | Byte-bus read data, combinational from offset and select |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe, advances the word position |
| dat_wdata | input | DATA_W | Data-port write word |
| dat_rdata | output | DATA_W | Current data-port word during a read transfer, else 0 |
| irq | output | 1 | Interrupt request, pending and not masked |

## Verification
Register and status reads are combinational, so the bench samples them in the same cycle in which the offset is presented. Every state change takes effect on the edge that captures the strobe. Busy therefore covers exactly the BUSY_CYCLES falling edges after a command, a reset or the last written word. A read command shows its data request on the falling edge BUSY_CYCLES+128 after the command, and irq rises together with that data request. The interrupt clear from a status read appears one cycle after the read. The bench drives strobes on falling edges and checks the expectation it queued for that same cycle one nanosecond later. This places each check on the exact cycle derived above, away from the rising edge.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
   localparam int LBA_W = 28;

   localparam int ST_BSY = 7;
   localparam int ST_RDY = 6;
   localparam int ST_DRQ = 3;
   localparam int ST_ERR = 0;

   localparam int ER_ABRT = 2;

   localparam int CT_SRST = 2;
   localparam int CT_NIEN = 1;

   localparam int DH_LBA = 6;

   localparam logic [7:0] CMD_RD_SECT = 8'h20;
   localparam logic [7:0] CMD_WR_SECT = 8'h30;

   typedef enum logic [2:0] {
      SQ_RESET,
      SQ_IDLE,
      SQ_WAIT,
      SQ_FILL,
      SQ_HOST_RD,
      SQ_HOST_WR,
      SQ_COMMIT
   } seq_st_t;

   typedef enum logic [2:0] {
      TF_DATA  = 3'd0,
      TF_ERROR = 3'd1,
      TF_COUNT = 3'd2,
      TF_LBA0  = 3'd3,
      TF_LBA1  = 3'd4,
      TF_LBA2  = 3'd5,
      TF_DEVHD = 3'd6,
      TF_CMDST = 3'd7
   } tf_off_t;
endpackage

// File: rtl/tfr_regfile.sv
module tfr_regfile
   import tfr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel_ctl,
   input  logic [2:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             busy,
   input  logic             drq,
   input  logic             abort_evt,
   input  logic             done_evt,
   output logic             cmd_go,
   output logic [7:0]       cmd_code,
   output logic             soft_rst,
   output logic [7:0]       sect_cnt,
   output logic [LBA_W-1:0] lba,
   output logic             lba_mode,
   output logic             nien,
   output logic             irq_pend,
   output logic             err_flag
);
   logic       tf_wr, ctl_wr, st_rd;
   logic [7:0] cnt_q, lba0_q, lba1_q, lba2_q, devhd_q, errreg_q;
   logic       nien_q, pend_q, err_q;
   logic [7:0] status;

   assign tf_wr    = bus_wr && !bus_sel_ctl && !busy;
   assign ctl_wr   = bus_wr && bus_sel_ctl;
   assign st_rd    = bus_rd && !bus_sel_ctl && (bus_addr == TF_CMDST);
   assign soft_rst = ctl_wr && bus_wdata[CT_SRST];
   assign cmd_go   = tf_wr && (bus_addr == TF_CMDST);
   assign cmd_code = bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         lba0_q   <= '0;
         lba1_q   <= '0;
         lba2_q   <= '0;
         devhd_q  <= '0;
         errreg_q <= '0;
         err_q    <= 1'b0;
         nien_q   <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         if (ctl_wr) nien_q <= bus_wdata[CT_NIEN];
         if (soft_rst) begin
            cnt_q    <= '0;
            lba0_q   <= '0;
            lba1_q   <= '0;
            lba2_q   <= '0;
            devhd_q  <= '0;
            errreg_q <= '0;
            err_q    <= 1'b0;
            pend_q   <= 1'b0;
         end else begin
            if (tf_wr) begin
               case (bus_addr)
                  TF_COUNT: cnt_q   <= bus_wdata;
                  TF_LBA0:  lba0_q  <= bus_wdata;
                  TF_LBA1:  lba1_q  <= bus_wdata;
                  TF_LBA2:  lba2_q  <= bus_wdata;
                  TF_DEVHD: devhd_q <= bus_wdata;
                  TF_CMDST: begin
                     err_q    <= 1'b0;
                     errreg_q <= '0;
                  end
                  default: ;
               endcase
            end
            if (abort_evt) begin
               err_q             <= 1'b1;
               errreg_q[ER_ABRT] <= 1'b1;
            end
            if (done_evt)   pend_q <= 1'b1;
            else if (st_rd) pend_q <= 1'b0;
         end
      end
   end

   always_comb begin
      status = '0;
      if (busy) begin
         status[ST_BSY] = 1'b1;
      end else begin
         status[ST_RDY] = 1'b1;
         status[ST_DRQ] = drq;
         status[ST_ERR] = err_q;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel_ctl) begin
         bus_rdata = status;
      end else begin
         case (bus_addr)
            TF_ERROR: bus_rdata = errreg_q;
            TF_COUNT: bus_rdata = cnt_q;
            TF_LBA0:  bus_rdata = lba0_q;
            TF_LBA1:  bus_rdata = lba1_q;
            TF_LBA2:  bus_rdata = lba2_q;
            TF_DEVHD: bus_rdata = devhd_q;
            TF_CMDST: bus_rdata = status;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign sect_cnt = cnt_q;
   assign lba      = {devhd_q[3:0], lba2_q, lba1_q, lba0_q};
   assign lba_mode = devhd_q[DH_LBA];
   assign nien     = nien_q;
   assign irq_pend = pend_q;
   assign err_flag = err_q;
endmodule

// File: rtl/tfr_seq.sv
module tfr_seq
   import tfr_pkg::*;
#(
   parameter int BUSY_CYCLES = 8,
   parameter int WORDS       = 128,
   parameter int DATA_W      = 32,
   localparam int PW         = $clog2(WORDS),
   localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic [7:0]        cmd_code,
   input  logic              soft_rst,
   input  logic [7:0]        sect_cnt,
   input  logic [LBA_W-1:0]  lba,
   input  logic              lba_mode,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic              busy,
   output logic              drq,
   output logic              rd_phase,
   output logic              abort_evt,
   output logic              done_evt,
   output logic              buf_we,
   output logic [PW-1:0]     buf_addr,
   output logic [DATA_W-1:0] buf_wdata
);
   localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYCLES - 1);
   localparam logic [PW-1:0] PTR_LAST = PW'(WORDS - 1);

   seq_st_t      st;
   logic [CW-1:0] cnt;
   logic [PW-1:0] ptr;
   logic [7:0]    op_q;
   logic          cmd_ok, cnt_zero, ptr_last;

   assign cmd_ok   = ((op_q == CMD_RD_SECT) || (op_q == CMD_WR_SECT)) &&
                     (sect_cnt == 8'd1) && lba_mode;
   assign cnt_zero = (cnt == '0);
   assign ptr_last = (ptr == PTR_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_RESET;
         cnt  <= CNT_LOAD;
         ptr  <= '0;
         op_q <= '0;
      end else if (soft_rst) begin
         st  <= SQ_RESET;
         cnt <= CNT_LOAD;
         ptr <= '0;
      end else begin
         unique case (st)
            SQ_RESET, SQ_COMMIT: begin
               if (!cnt_zero) cnt <= cnt - 1'b1;
               else           st  <= SQ_IDLE;
            end
            SQ_WAIT: begin
               if (!cnt_zero) begin
                  cnt <= cnt - 1'b1;
               end else begin
                  ptr <= '0;
                  if (!cmd_ok)                  st <= SQ_IDLE;
                  else if (op_q == CMD_RD_SECT) st <= SQ_FILL;
                  else                          st <= SQ_HOST_WR;
               end
            end
            SQ_FILL: begin
               ptr <= ptr + 1'b1;
               if (ptr_last) st <= SQ_HOST_RD;
            end
            SQ_HOST_RD: begin
               if (cmd_go) begin
                  st   <= SQ_WAIT;
                  cnt  <= CNT_LOAD;
                  op_q <= cmd_code;
               end else if (dat_rd) begin
                  ptr <= ptr + 1'b1;
                  if (ptr_last) st <= SQ_IDLE;
               end
            end
            SQ_HOST_WR: begin
               if (cmd_go) begin
                  st   <= SQ_WAIT;
                  cnt  <= CNT_LOAD;
                  op_q <= cmd_code;
               end else if (dat_wr) begin
                  ptr <= ptr + 1'b1;
                  if (ptr_last) begin
                     st  <= SQ_COMMIT;
                     cnt <= CNT_LOAD;
                  end
               end
            end
            SQ_IDLE: begin
               if (cmd_go) begin
                  st   <= SQ_WAIT;
                  cnt  <= CNT_LOAD;
                  op_q <= cmd_code;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (st == SQ_RESET) || (st == SQ_WAIT) ||
                      (st == SQ_FILL)  || (st == SQ_COMMIT);
   assign drq       = (st == SQ_HOST_RD) || (st == SQ_HOST_WR);
   assign rd_phase  = (st == SQ_HOST_RD);
   assign abort_evt = (st == SQ_WAIT) && cnt_zero && !cmd_ok;
   assign done_evt  = abort_evt ||
                      ((st == SQ_FILL) && ptr_last) ||
                      ((st == SQ_COMMIT) && cnt_zero);

   assign buf_we    = (st == SQ_FILL) || ((st == SQ_HOST_WR) && dat_wr && !cmd_go);
   assign buf_addr  = ptr;
   assign buf_wdata = (st == SQ_FILL) ? DATA_W'({lba, ptr}) : dat_wdata;
endmodule

// File: rtl/tfr_secbuf.sv
module tfr_secbuf #(
   parameter int WORDS        = 128,
   parameter int DATA_W       = 32,
   parameter bit CLEAR_ON_RST = 1'b1,
   localparam int AW          = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [WORDS];

   generate
      if (CLEAR_ON_RST) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/sector_taskfile.sv
module sector_taskfile
   import tfr_pkg::*;
#(
   parameter int BUSY_CYCLES = 8,
   parameter int WORDS       = 128,
   parameter int DATA_W      = 32,
   parameter bit CLEAR_BUF   = 1'b1,
   localparam int PW         = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_ctl,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic [DATA_W-1:0] dat_rdata,
   output logic              irq
);
   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
      if (WORDS < 2 || WORDS != (1 << PW)) begin : g_bad_words
         $error("WORDS must be a power of two, at least 2");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic              seq_busy, seq_drq, rd_phase, abort_evt, done_evt;
   logic              cmd_go, soft_rst, lba_mode, nien_q, irq_pend, err_flag;
   logic [7:0]        cmd_code, sect_cnt;
   logic [LBA_W-1:0]  lba;
   logic              buf_we;
   logic [PW-1:0]     buf_addr;
   logic [DATA_W-1:0] buf_wdata, buf_rdata;

   tfr_regfile u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel_ctl(bus_sel_ctl),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .busy      (seq_busy),
      .drq       (seq_drq),
      .abort_evt (abort_evt),
      .done_evt  (done_evt),
      .cmd_go    (cmd_go),
      .cmd_code  (cmd_code),
      .soft_rst  (soft_rst),
      .sect_cnt  (sect_cnt),
      .lba       (lba),
      .lba_mode  (lba_mode),
      .nien      (nien_q),
      .irq_pend  (irq_pend),
      .err_flag  (err_flag)
   );

   tfr_seq #(
      .BUSY_CYCLES(BUSY_CYCLES),
      .WORDS      (WORDS),
      .DATA_W     (DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_go    (cmd_go),
      .cmd_code  (cmd_code),
      .soft_rst  (soft_rst),
      .sect_cnt  (sect_cnt),
      .lba       (lba),
      .lba_mode  (lba_mode),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd),
      .dat_wdata (dat_wdata),
      .busy      (seq_busy),
      .drq       (seq_drq),
      .rd_phase  (rd_phase),
      .abort_evt (abort_evt),
      .done_evt  (done_evt),
      .buf_we    (buf_we),
      .buf_addr  (buf_addr),
      .buf_wdata (buf_wdata)
   );

   tfr_secbuf #(
      .WORDS       (WORDS),
      .DATA_W      (DATA_W),
      .CLEAR_ON_RST(CLEAR_BUF)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (buf_we),
      .waddr (buf_addr),
      .wdata (buf_wdata),
      .raddr (buf_addr),
      .rdata (buf_rdata)
   );

   assign dat_rdata = rd_phase ? buf_rdata : '0;
   assign irq       = irq_pend && !nien_q;
endmodule

// File: rtl/tfr_chk.sv
module tfr_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel_ctl,
   input logic [2:0]        bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_rdata,
   input logic [DATA_W-1:0] dat_rdata,
   input logic              irq,
   input logic              busy,
   input logic              drq,
   input logic              nien,
   input logic              err,
   input logic              done_evt
);
   AST_BUSY_HIDES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel_ctl && bus_rdata[7]) |-> (bus_rdata[6:0] == 7'd0))
      else $error("busy status shows other bits"); // R3

   AST_CMD_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel_ctl && bus_addr == 3'd7 && !busy) |=> busy)
      else $error("accepted command did not raise busy"); // R3

   AST_BUSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !drq)
      else $error("busy and data request together"); // R4

   AST_STATUS_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_sel_ctl && bus_addr == 3'd7 && !done_evt) |=> !irq)
      else $error("status read left irq high"); // R6

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      nien |-> !irq)
      else $error("irq high while masked"); // R7

   AST_ABORT_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !drq)
      else $error("data request with error set"); // R8

   AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !drq |-> (dat_rdata == '0))
      else $error("data port not zero outside transfer"); // R11
endmodule

bind sector_taskfile tfr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel_ctl(bus_sel_ctl),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .dat_rdata  (dat_rdata),
   .irq        (irq),
   .busy       (seq_busy),
   .drq        (seq_drq),
   .nien       (nien_q),
   .err        (err_flag),
   .done_evt   (done_evt)
);

// File: tb/sector_taskfile_tb_top.sv
`timescale 1ns/1ps
module sector_taskfile_tb_top;
   localparam int B = 8;
   localparam logic [27:0] LBA = 28'h5561234;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel_ctl = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        dat_wr = 1'b0;
   logic        dat_rd = 1'b0;
   logic [31:0] dat_wdata = '0;
   logic [31:0] dat_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic        mon_req = 1'b0;
   int          kind_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   sector_taskfile #(.BUSY_CYCLES(B)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel_ctl(bus_sel_ctl), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
      .irq(irq)
   );

   // monitor: pops one expected item per requested cycle and compares
   always begin
      @(negedge clk);
      #1;
      if (mon_req && kind_q.size() > 0) begin
         int          k;
         logic [31:0] e, a;
         string       t;
         k = kind_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         if (k == 0)      a = {24'd0, bus_rdata};
         else if (k == 1) a = dat_rdata;
         else             a = {31'd0, irq};
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, a, e);
         end
      end
   end

   task automatic push(input int k, input logic [31:0] e, input string t);
      kind_q.push_back(k);
      exp_q.push_back(e);
      tag_q.push_back(t);
      mon_req = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bwr(input logic ctl, input logic [2:0] a, input logic [7:0] d);
      bus_sel_ctl = ctl; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_sel_ctl = 1'b0;
   endtask

   task automatic brd(input logic ctl, input logic [2:0] a, input logic [7:0] e, input string t);
      bus_sel_ctl = ctl; bus_addr = a; bus_rd = 1'b1;
      push(0, {24'd0, e}, t);
      @(negedge clk);
      bus_rd = 1'b0; bus_sel_ctl = 1'b0; mon_req = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      push(2, {31'd0, e}, t);
      @(negedge clk);
      mon_req = 1'b0;
   endtask

   task automatic drd(input logic [31:0] e, input logic strobe, input string t);
      dat_rd = strobe;
      push(1, e, t);
      @(negedge clk);
      dat_rd = 1'b0; mon_req = 1'b0;
   endtask

   task automatic dwr(input logic [31:0] d);
      dat_wdata = d; dat_wr = 1'b1;
      @(negedge clk);
      dat_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      brd(1, 0, 8'h80, "R1 busy after reset");
      idle(B - 2);
      brd(1, 0, 8'h80, "R1 busy last cycle");
      brd(1, 0, 8'h40, "R1 ready");
      brd(0, 1, 8'h00, "R1 error byte");
      chk_irq(1'b0, "R1 irq low");

      // R11 data port outside a transfer
      drd(32'h0, 1'b0, "R11 idle data zero");
      dwr(32'hDEADBEEF);
      drd(32'h0, 1'b1, "R11 idle read zero");

      // R2 register map
      bwr(0, 2, 8'h01);
      bwr(0, 3, 8'h34);
      bwr(0, 4, 8'h12);
      bwr(0, 5, 8'h56);
      bwr(0, 6, 8'hE5);
      brd(0, 2, 8'h01, "R2 count");
      brd(0, 3, 8'h34, "R2 lba low");
      brd(0, 4, 8'h12, "R2 lba mid");
      brd(0, 5, 8'h56, "R2 lba high");
      brd(0, 6, 8'hE5, "R2 drive/head");
      brd(0, 0, 8'h00, "R2 byte data offset");

      // R4 read sector
      bwr(0, 7, 8'h20);
      brd(1, 0, 8'h80, "R3 busy after read cmd");
      idle(B + 126);
      brd(1, 0, 8'h80, "R4 busy during fill");
      brd(1, 0, 8'h48, "R4 drq after fill");
      chk_irq(1'b1, "R6 irq with read data");
      for (int i = 0; i < 128; i++) begin
         logic [34:0] w;
         w = {LBA, 7'(i)};
         drd(w[31:0], 1'b1, $sformatf("R4 word %0d", i));
      end
      brd(1, 0, 8'h40, "R4 drq off after 128");
      chk_irq(1'b1, "R6 ctl read keeps irq");
      brd(0, 7, 8'h40, "R6 status read");
      chk_irq(1'b0, "R6 status read clears");

      // R5 write sector, R9 writes while busy
      bwr(0, 7, 8'h30);
      bwr(0, 2, 8'h09);
      bwr(0, 7, 8'h99);
      idle(B - 3);
      brd(1, 0, 8'h80, "R3 busy after write cmd");
      brd(1, 0, 8'h48, "R5 drq for write");
      brd(0, 2, 8'h01, "R9 count unchanged");
      drd(32'h0, 1'b0, "R11 data zero during write");
      for (int i = 0; i < 128; i++) dwr(32'(i * 3 + 1));
      brd(1, 0, 8'h80, "R5 commit busy");
      idle(B - 2);
      brd(1, 0, 8'h80, "R5 commit busy last");
      brd(1, 0, 8'h40, "R5 ready after commit");
      chk_irq(1'b1, "R6 irq after write");
      brd(0, 7, 8'h40, "R6 status read");

      // R8 aborts, R7 masking
      bwr(1, 0, 8'h02);
      bwr(0, 2, 8'h02);
      bwr(0, 7, 8'h20);
      idle(B - 1);
      brd(1, 0, 8'h80, "R8 busy before abort");
      brd(1, 0, 8'h41, "R8 abort bad count");
      chk_irq(1'b0, "R7 masked irq");
      brd(0, 1, 8'h04, "R8 abort cause");
      bwr(1, 0, 8'h00);
      chk_irq(1'b1, "R7 unmask shows pending");
      brd(0, 7, 8'h41, "R8 status error");
      bwr(0, 2, 8'h01);
      bwr(0, 6, 8'hA5);
      bwr(0, 7, 8'h30);
      idle(B);
      brd(1, 0, 8'h41, "R8 abort chs mode");
      bwr(0, 7, 8'h77);
      idle(B);
      brd(1, 0, 8'h41, "R8 abort unknown code");

      // R12 accepted command clears error
      bwr(0, 6, 8'hE5);
      bwr(0, 7, 8'h30);
      brd(0, 1, 8'h00, "R12 error byte cleared");
      idle(B - 1);
      brd(1, 0, 8'h48, "R12 drq without error");

      // R10 soft reset mid transfer
      bwr(1, 0, 8'h04);
      brd(1, 0, 8'h80, "R10 busy after soft reset");
      idle(B - 2);
      brd(1, 0, 8'h80, "R10 busy last");
      brd(1, 0, 8'h40, "R10 ready no drq");
      brd(0, 2, 8'h00, "R10 count cleared");
      brd(0, 6, 8'h00, "R10 drive/head cleared");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule